// File: doc/BRIEF.md
# Periodic, Alarm and Update Interrupt Controller

This block collects the three interrupt causes of a real-time clock: a periodic tick taken from the oscillator timebase, a time-of-day alarm, and the end of each clock update. Each cause has its own sticky flag and its own enable. Together they drive one shared active-low interrupt line. The same rate divider that paces the periodic interrupt also produces a square wave. Software finds the cause in a status byte, and reading that byte clears the flags.

The rate code picks a power-of-two division of the timebase tick. The alarm compares the hours, minutes and seconds bytes against three alarm bytes, and any of those bytes can be marked "match anything". A read is a level strobe. While it is held, the status byte stays frozen and new events are parked. When the read ends, the old flags are dropped and the parked events become the new flags.

Top module: `rtc_irq_unit`

## Requirements
- R1: An active-low asynchronous reset clears the flags, the parked events, the three enables and the rate divider. After reset, `statusByte` reads 0, `irqN` is 1 and `sqwOut` is 0.
- R2: The divider counts `tbTick` pulses from reset. For rate code 1 the period P is 128 ticks, for code 2 it is 256 ticks, and for codes 3..15 it is 2^(code-1) ticks. The periodic flag (status bit 6) is set on the clock edge that registers every tick which brings the tick count to a multiple of P.
- R3: On an `updEnd` pulse, the alarm flag (status bit 5) is set if each of the three bytes matches. Seconds are in bits 7:0, minutes in 15:8 and hours in 23:16. A byte matches when the alarm byte equals the time byte, or when the alarm byte has bits 7 and 6 both 1.
- R4: `sqwOut` equals bit log2(P)-1 of the tick count when `sqwEn` is 1 and the rate code is nonzero. Otherwise it is 0.
- R5: The update flag (status bit 4) is set on every `updEnd` pulse, whatever the state of its enable.
- R6: Status bit 7 is the OR of each flag ANDed with its enable. `irqN` is the inverse of bit 7.
- R7: While `statRd` is 1 the flags do not change, and events are parked. On the edge after `statRd` falls, the flags become the parked events together with any event on that same edge, and all earlier flags are cleared.
- R8: While `setBit` is 1, the update enable is cleared, and a write that tries to set it has no effect.
- R9: A pulse on `enWr` loads `pieIn`, `aieIn` and `uieIn` into the periodic, alarm and update enables. Status bits 3:0 always read 0.
- R10: Rate code 0 stops the periodic flag from being set and holds `sqwOut` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tbTick | input | 1 | One-cycle timebase tick |
| updEnd | input | 1 | One-cycle update-finished pulse |
| curTime | input | 24 | Current hours, minutes, seconds |
| alarmSet | input | 24 | Alarm hours, minutes, seconds |
| rateSel | input | 4 | Rate code |
| sqwEn | input | 1 | Square-wave enable |
| enWr | input | 1 | Enable load strobe |
| pieIn | input | 1 | Periodic enable value |
| aieIn | input | 1 | Alarm enable value |
| uieIn | input | 1 | Update enable value |
| setBit | input | 1 | Clock-set mode; forces update enable off |
| statRd | input | 1 | Status read in progress |
| irqN | output | 1 | Shared interrupt, active low |
| statusByte | output | 8 | Interrupt status and flags |
| sqwOut | output | 1 | Square-wave output |

## Verification
A flag is due one clock after the edge that samples its tick, `updEnd` pulse or read end. `irqN`, status bit 7 and `sqwOut` follow the registered state combinationally within the same cycle. The bench drives inputs 1 ns after each rising edge. A behavioural model updates its state on the same rising edge, and every output is compared against the model on the falling edge, so each result is observed in the first cycle it is due. Directed checks follow the same timing: a pulse driven after one rising edge is checked at the falling edge that follows the next rising edge.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int FLAG_N = 3;
  localparam int STAT_W = 8;

  typedef struct packed {
    logic pfSet;
    logic afSet;
    logic ufSet;
    logic rdBusy;
    logic rdDone;
  } irqStrobes_t;
endpackage

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_irq_pkg::*;
#(
  parameter int DIV_W     = 14,
  parameter int SLOW1_TAP = 7,
  parameter int SLOW2_TAP = 8,
  parameter int RATE_W    = 4,
  parameter int FIELD_N   = 3,
  parameter int FIELD_W   = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       tbTick,
  input  logic                       updEnd,
  input  logic                       statRd,
  input  logic [RATE_W-1:0]          rateSel,
  input  logic                       sqwEn,
  input  logic [FIELD_N*FIELD_W-1:0] curTime,
  input  logic [FIELD_N*FIELD_W-1:0] alarmSet,
  output irqStrobes_t                strobes,
  output logic                       sqwOut
);
  localparam int TAP_W = $clog2(DIV_W + 1);

  logic [DIV_W-1:0]   divCnt;
  logic [TAP_W-1:0]   tapIdx;
  logic [DIV_W-1:0]   lowMask;
  logic [DIV_W-1:0]   topBit;
  logic               rateOn;
  logic               rdPrev;
  logic [FIELD_N-1:0] fieldHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else if (tbTick) divCnt <= divCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdPrev <= 1'b0;
    else rdPrev <= statRd;
  end

  always_comb begin
    case (rateSel)
      RATE_W'(0): tapIdx = '0;
      RATE_W'(1): tapIdx = TAP_W'(SLOW1_TAP);
      RATE_W'(2): tapIdx = TAP_W'(SLOW2_TAP);
      default:    tapIdx = TAP_W'(rateSel) - 1'b1;
    endcase
  end

  always_comb begin
    for (int i = 0; i < DIV_W; i++) lowMask[i] = (i < int'(tapIdx));
  end

  assign topBit = lowMask & ~(lowMask >> 1);
  assign rateOn = (rateSel != '0);
  assign sqwOut = sqwEn && rateOn && (|(divCnt & topBit));

  for (genvar g = 0; g < FIELD_N; g++) begin : g_field
    logic [FIELD_W-1:0] aByte;
    logic [FIELD_W-1:0] tByte;
    assign aByte       = alarmSet[g*FIELD_W +: FIELD_W];
    assign tByte       = curTime[g*FIELD_W +: FIELD_W];
    assign fieldHit[g] = (&aByte[FIELD_W-1 -: 2]) || (aByte == tByte);
  end

  assign strobes.pfSet  = tbTick && rateOn && ((divCnt & lowMask) == lowMask);
  assign strobes.afSet  = updEnd && (&fieldHit);
  assign strobes.ufSet  = updEnd;
  assign strobes.rdBusy = statRd;
  assign strobes.rdDone = !statRd && rdPrev;

  // R3
  af_upd_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.afSet |-> strobes.ufSet);

  // R2
  pf_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pfSet |=> (!strobes.pfSet || rateSel != $past(rateSel)));
endmodule

// File: rtl/rtc_irq_dp.sv
module rtc_irq_dp
  import rtc_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  irqStrobes_t       strobes,
  input  logic              enWr,
  input  logic              pieIn,
  input  logic              aieIn,
  input  logic              uieIn,
  input  logic              setBit,
  output logic              irqN,
  output logic [STAT_W-1:0] statusByte
);
  logic [FLAG_N-1:0] flags;
  logic [FLAG_N-1:0] pend;
  logic [FLAG_N-1:0] enVec;
  logic [FLAG_N-1:0] evtVec;
  logic              irqFlag;

  assign evtVec = {strobes.pfSet, strobes.afSet, strobes.ufSet};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags <= '0;
      pend  <= '0;
    end else if (strobes.rdBusy) begin
      pend <= pend | evtVec;
    end else if (strobes.rdDone) begin
      flags <= pend | evtVec;
      pend  <= '0;
    end else begin
      flags <= flags | evtVec;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enVec <= '0;
    end else begin
      if (enWr) enVec[2:1] <= {pieIn, aieIn};
      if (setBit) enVec[0] <= 1'b0;
      else if (enWr) enVec[0] <= uieIn;
    end
  end

  assign irqFlag    = |(flags & enVec);
  assign irqN       = !irqFlag;
  assign statusByte = {irqFlag, flags, {(STAT_W-FLAG_N-1){1'b0}}};

  // R7
  rd_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rdBusy |=> $stable(flags));

  // R8
  set_uie_chk: assert property (@(posedge clk) disable iff (!rstN)
    setBit |=> !enVec[0]);

  // R6
  irq_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    !irqN |-> (|flags));

  // R5
  uf_post_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.ufSet && !strobes.rdBusy) |=> flags[0]);
endmodule

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit
  import rtc_irq_pkg::*;
#(
  parameter int DIV_W   = 14,
  parameter int RATE_W  = 4,
  parameter int FIELD_N = 3,
  parameter int FIELD_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       tbTick,
  input  logic                       updEnd,
  input  logic [FIELD_N*FIELD_W-1:0] curTime,
  input  logic [FIELD_N*FIELD_W-1:0] alarmSet,
  input  logic [RATE_W-1:0]          rateSel,
  input  logic                       sqwEn,
  input  logic                       enWr,
  input  logic                       pieIn,
  input  logic                       aieIn,
  input  logic                       uieIn,
  input  logic                       setBit,
  input  logic                       statRd,
  output logic                       irqN,
  output logic [STAT_W-1:0]          statusByte,
  output logic                       sqwOut
);
  irqStrobes_t strobes;

  rtc_irq_ctrl #(
    .DIV_W(DIV_W), .SLOW1_TAP(7), .SLOW2_TAP(8),
    .RATE_W(RATE_W), .FIELD_N(FIELD_N), .FIELD_W(FIELD_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .tbTick(tbTick), .updEnd(updEnd),
    .statRd(statRd), .rateSel(rateSel), .sqwEn(sqwEn),
    .curTime(curTime), .alarmSet(alarmSet),
    .strobes(strobes), .sqwOut(sqwOut)
  );

  rtc_irq_dp u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .enWr(enWr),
    .pieIn(pieIn), .aieIn(aieIn), .uieIn(uieIn), .setBit(setBit),
    .irqN(irqN), .statusByte(statusByte)
  );
endmodule

// File: tb/rtc_irq_unit_bench.sv
module rtc_irq_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tbTick = 1'b0, updEnd = 1'b0, sqwEn = 1'b0, enWr = 1'b0;
  logic        pieIn = 1'b0, aieIn = 1'b0, uieIn = 1'b0, setBit = 1'b0, statRd = 1'b0;
  logic [23:0] curTime = '0, alarmSet = '0;
  logic [3:0]  rateSel = '0;
  logic        irqN, sqwOut;
  logic [7:0]  statusByte;

  int checks = 0, fails = 0, tickMode = 0;
  bit done = 0;

  // model state
  int  mCnt = 0;
  bit  mPf, mAf, mUf, pPf, pAf, pUf, ePie, eAie, eUie, mRdPrev;

  always #4 clk = ~clk;

  rtc_irq_unit u_rtc_irq_unit (
    .clk(clk), .rstN(rstN), .tbTick(tbTick), .updEnd(updEnd),
    .curTime(curTime), .alarmSet(alarmSet), .rateSel(rateSel), .sqwEn(sqwEn),
    .enWr(enWr), .pieIn(pieIn), .aieIn(aieIn), .uieIn(uieIn), .setBit(setBit),
    .statRd(statRd), .irqN(irqN), .statusByte(statusByte), .sqwOut(sqwOut)
  );

  function automatic int periodOf(input logic [3:0] rs);
    if (rs == 0) return 0;
    if (rs == 1) return 128;
    if (rs == 2) return 256;
    return 1 << (rs - 1);
  endfunction

  function automatic bit byteOk(input logic [7:0] a, input logic [7:0] t);
    return (a[7:6] == 2'b11) || (a == t);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCnt = 0; {mPf, mAf, mUf, pPf, pAf, pUf, ePie, eAie, eUie, mRdPrev} = '0;
    end else begin
      int p;
      bit ePf, eAf, eUf;
      p   = periodOf(rateSel);
      ePf = tbTick && p != 0 && ((mCnt % p) == p - 1);
      eUf = updEnd;
      eAf = updEnd && byteOk(alarmSet[7:0], curTime[7:0]) &&
            byteOk(alarmSet[15:8], curTime[15:8]) && byteOk(alarmSet[23:16], curTime[23:16]);
      if (tbTick) mCnt = (mCnt + 1) % 16384;
      if (statRd) begin
        pPf |= ePf; pAf |= eAf; pUf |= eUf;
      end else if (mRdPrev) begin
        mPf = pPf | ePf; mAf = pAf | eAf; mUf = pUf | eUf;
        pPf = 0; pAf = 0; pUf = 0;
      end else begin
        mPf |= ePf; mAf |= eAf; mUf |= eUf;
      end
      mRdPrev = statRd;
      if (enWr) begin ePie = pieIn; eAie = aieIn; end
      if (setBit) eUie = 0; else if (enWr) eUie = uieIn;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cmpAll(input string tag);
    int p, k;
    bit irq, sq;
    p   = periodOf(rateSel);
    k   = (p == 0) ? 0 : $clog2(p);
    irq = (mPf & ePie) | (mAf & eAie) | (mUf & eUie);
    sq  = sqwEn && p != 0 && (((mCnt >> (k - 1)) & 1) != 0);
    chk({tag, " R2 periodic flag"}, statusByte[6], mPf);
    chk({tag, " R3 alarm flag"}, statusByte[5], mAf);
    chk({tag, " R5 update flag"}, statusByte[4], mUf);
    chk({tag, " R6 irq bit"}, statusByte[7], irq);
    chk({tag, " R6 irqN"}, irqN, !irq);
    chk({tag, " R9 low bits"}, statusByte[3:0], 0);
    chk({tag, " R4 square wave"}, sqwOut, sq);
  endtask

  initial forever begin
    @(negedge clk);
    if (rstN) cmpAll("cycle");
  end

  initial forever begin
    @(posedge clk); #1;
    tbTick = (tickMode == 1) || (tickMode == 2 && ($urandom % 4) != 0);
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic doRead();
    statRd = 1; step(2); statRd = 0; step(2);
  endtask

  task automatic pulseUpd();
    updEnd = 1; step(1); updEnd = 0;
  endtask

  task automatic alarmCase(input logic [23:0] t, input logic [23:0] a, input bit exp);
    curTime = t; alarmSet = a;
    doRead(); pulseUpd();
    @(negedge clk);
    chk("R3 alarm directed", statusByte[5], exp);
    chk("R5 update directed", statusByte[4], 1);
    step(1);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin @(posedge clk); cyc++; end
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    step(4);
    @(negedge clk);
    chk("R1 reset status", statusByte, 0);
    chk("R1 reset irqN", irqN, 1);
    chk("R1 reset sqw", sqwOut, 0);
    rstN = 1; step(2);

    // R9 enable load, R2 / R4 at fastest rate
    pieIn = 1; aieIn = 1; uieIn = 1; enWr = 1; step(1); enWr = 0;
    rateSel = 3; sqwEn = 1; tickMode = 1; step(40);
    @(negedge clk); chk("R6 irq from periodic", irqN, 0);
    step(1); doRead();

    // R2 / R4 rate sweep
    for (int rs = 1; rs < 16; rs++) begin
      rateSel = 4'(rs); doRead();
      step(periodOf(4'(rs)) + 2);
      @(negedge clk); chk("R2 rate sweep flag", statusByte[6], 1);
      step(1);
    end
    tickMode = 2; rateSel = 4; step(300);

    // R3 alarm compare
    alarmCase(24'h12_34_56, 24'h12_34_56, 1);
    alarmCase(24'h12_34_56, 24'h12_35_56, 0);
    alarmCase(24'h09_34_56, 24'hC0_34_56, 1);
    alarmCase(24'h01_02_03, 24'hFF_FF_FF, 1);
    alarmCase(24'h01_02_03, 24'h01_02_C3, 1);
    alarmCase(24'h01_02_03, 24'h81_02_03, 0);

    // R7 event during read is held
    tickMode = 0; doRead();
    statRd = 1; step(1); pulseUpd();
    @(negedge clk); chk("R7 flag frozen during read", statusByte[4], 0);
    step(1); statRd = 0; step(1);
    @(negedge clk); chk("R7 held event posted", statusByte[4], 1);
    step(1);

    // R8 set mode blocks update enable
    pieIn = 0; aieIn = 0; uieIn = 1; setBit = 1; enWr = 1; step(1); enWr = 0;
    doRead(); pulseUpd();
    @(negedge clk);
    chk("R8 uie held off", irqN, 1);
    chk("R5 flag without enable", statusByte[4], 1);
    step(1); setBit = 0; enWr = 1; step(1); enWr = 0;
    @(negedge clk); chk("R9 uie loaded", irqN, 0);
    step(1);

    // R10 rate code zero
    rateSel = 0; sqwEn = 1; tickMode = 1; pieIn = 1; enWr = 1; step(1); enWr = 0;
    doRead();
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      chk("R10 no periodic", statusByte[6], 0);
      chk("R10 sqw low", sqwOut, 0);
      step(1);
    end

    // R1 reset mid-run
    rateSel = 5; step(50); pulseUpd(); step(2);
    rstN = 0; step(1);
    @(negedge clk);
    chk("R1 mid reset status", statusByte, 0);
    chk("R1 mid reset irqN", irqN, 1);
    chk("R1 mid reset sqw", sqwOut, 0);
    step(1); rstN = 1; tickMode = 2; step(500);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule